// File: doc/BRIEF.md
# Video Standard Detector with Pixel-Clock Select

This block decides whether a retro-video capture design should run its pixel clock at the PAL rate (about 7.882 MHz) or the NTSC rate (about 8.18 MHz). It also reports which system type the video pipeline is really attached to. It runs entirely in a free-running reference clock domain and has two independent detection paths.

The first path reads a single strap pin that carries a weak pull-up. The pin has three meanings:
- Left open, it reads high, and the pixel clock stays at PAL.
- Held low, it raises a flag for a legacy compatibility setting, and the pixel clock still stays at PAL.
- Wired back to the design's own pixel-clock output, it toggles, and this requests the NTSC pixel clock.

The second path counts rising edges of the returning system clock, which is the pixel clock divided by eight (0.98525 MHz for PAL), over a fixed window of reference cycles. It classifies each window's count as PAL, NTSC or out of range.

Neither path acts on a single window. A class is taken only when two consecutive windows agree. All outputs move only in the cycle right after a window boundary. A disagreement flag is raised when the accepted system-clock type differs from the pixel-clock selection.

Top module: `vid_std_detect`

## Requirements
- R1: While reset is held, and on leaving it, `ntsc_sel`, `compat_lo`, `sys_ntsc`, `sys_valid` and `mismatch` are all 0, so the pixel clock selection is PAL.
- R2: When the strap pin shows at least `TOGGLE_MIN` synchronised edges (rising plus falling) in each of two consecutive windows, `ntsc_sel` becomes 1 and `compat_lo` becomes 0.
- R3: When the strap pin is steadily high (zero edges, level 1) for two consecutive windows, `ntsc_sel` is 0 and `compat_lo` is 0.
- R4: When the strap pin is steadily low (zero edges, level 0) for two consecutive windows, `compat_lo` is 1 and `ntsc_sel` is 0.
- R5: A burst of toggling whose edges cannot reach `TOGGLE_MIN` in two consecutive windows leaves `ntsc_sel` and `compat_lo` unchanged.
- R6: A window with between 1 and `TOGGLE_MIN`-1 strap edges is inconclusive. A steady run of such windows leaves `ntsc_sel` and `compat_lo` at their previous values.
- R7: When two consecutive windows each count between `PAL_LO` and `PAL_HI` system-clock rising edges (inclusive), `sys_valid` is 1 and `sys_ntsc` is 0.
- R8: When two consecutive windows each count between `NTSC_LO` and `NTSC_HI` rising edges (inclusive), `sys_valid` is 1 and `sys_ntsc` is 1.
- R9: When two consecutive windows each count outside both ranges, including a stopped clock, `sys_valid` is 0 and `sys_ntsc` keeps its previous value.
- R10: Every output changes only on the clock edge that ends a window. That is the edge numbered k*`WIN_CYC` after reset release, where the first edge with reset released is edge 1.
- R11: `mismatch` is 1 exactly when `sys_valid` is 1 and `sys_ntsc` differs from `ntsc_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_in | input | 1 | Asynchronous three-state strap pin (low, pulled-up open, or toggling) |
| sys_clk_in | input | 1 | Asynchronous returning system clock, sampled as data |
| ntsc_sel | output | 1 | Pixel clock select to the clock generator: 1 = NTSC, 0 = PAL |
| compat_lo | output | 1 | Strap accepted as steadily low (legacy compatibility setting) |
| sys_ntsc | output | 1 | Accepted system type: 1 = NTSC, 0 = PAL |
| sys_valid | output | 1 | System-clock measurement is in a recognised range |
| mismatch | output | 1 | Strap request and measured system type disagree |

## Verification
The strap decision and the system-clock decision are taken at the same window boundary. Both can therefore change in one cycle, and the disagreement flag depends on both at once.

The bench provokes this by switching the strap mode and the system-clock frequency at the same instant, for every combination of three strap states and four clock conditions. It then judges the settled outputs and the flag against values worked out arithmetically.

A cycle monitor, counting edges from reset release, catches any output that moves off a window boundary while the two paths are settling together.

// File: rtl/vid_std_detect.sv
module vid_std_detect #(
  parameter int WIN_CYC    = 20000,
  parameter int TOGGLE_MIN = 64,
  parameter int PAL_LO     = 194,
  parameter int PAL_HI     = 200,
  parameter int NTSC_LO    = 202,
  parameter int NTSC_HI    = 208
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic strap_in,
  input  logic sys_clk_in,
  output logic ntsc_sel,
  output logic compat_lo,
  output logic sys_ntsc,
  output logic sys_valid,
  output logic mismatch
);
  localparam int CW = $clog2(WIN_CYC + 1);

  typedef enum logic [1:0] {ST_HIGH = 2'd0, ST_LOW = 2'd1, ST_TOG = 2'd2, ST_UNSURE = 2'd3} strap_cls_t;
  typedef enum logic [1:0] {SC_PAL = 2'd0, SC_NTSC = 2'd1, SC_BAD = 2'd2} sys_cls_t;

  logic [2:0] strap_sh, sys_sh;
  logic [CW-1:0] win_cnt, s_cnt, c_cnt, s_tot, c_tot;
  logic win_end, s_edge, c_rise;
  strap_cls_t s_cls, s_prev, s_acc;
  sys_cls_t   c_cls, c_prev;

  assign win_end = (win_cnt == CW'(WIN_CYC - 1));
  assign s_edge  = strap_sh[2] ^ strap_sh[1];
  assign c_rise  = sys_sh[1] & ~sys_sh[2];
  assign s_tot   = s_cnt + CW'(s_edge);
  assign c_tot   = c_cnt + CW'(c_rise);

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      strap_sh <= '0;
      sys_sh   <= '0;
      win_cnt  <= '0;
      s_cnt    <= '0;
      c_cnt    <= '0;
    end else begin
      strap_sh <= {strap_sh[1:0], strap_in};
      sys_sh   <= {sys_sh[1:0], sys_clk_in};
      win_cnt  <= win_end ? '0 : win_cnt + 1'b1;
      s_cnt    <= win_end ? '0 : s_tot;
      c_cnt    <= win_end ? '0 : c_tot;
    end
  end

  always_comb begin
    if (s_tot >= CW'(TOGGLE_MIN))  s_cls = ST_TOG;
    else if (s_tot != '0)          s_cls = ST_UNSURE;
    else if (strap_sh[1])          s_cls = ST_HIGH;
    else                           s_cls = ST_LOW;
    if (c_tot >= CW'(PAL_LO) && c_tot <= CW'(PAL_HI))        c_cls = SC_PAL;
    else if (c_tot >= CW'(NTSC_LO) && c_tot <= CW'(NTSC_HI)) c_cls = SC_NTSC;
    else                                                      c_cls = SC_BAD;
  end

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      s_prev    <= ST_UNSURE;
      s_acc     <= ST_HIGH;
      c_prev    <= SC_BAD;
      sys_ntsc  <= 1'b0;
      sys_valid <= 1'b0;
    end else if (win_end) begin
      s_prev <= s_cls;
      c_prev <= c_cls;
      if (s_cls == s_prev && s_cls != ST_UNSURE) s_acc <= s_cls;
      if (c_cls == c_prev) begin
        sys_valid <= (c_cls != SC_BAD);
        if (c_cls != SC_BAD) sys_ntsc <= (c_cls == SC_NTSC);
      end
    end
  end

  assign ntsc_sel  = (s_acc == ST_TOG);
  assign compat_lo = (s_acc == ST_LOW);
  assign mismatch  = sys_valid && (sys_ntsc != ntsc_sel);

  assert_reset_pal_R1: assert property (@(posedge clk_ref)
    !rst_n |=> (!ntsc_sel && !sys_valid && !compat_lo && !sys_ntsc));
  assert_sel_on_window_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(ntsc_sel) |-> $past(win_end));
  assert_compat_on_window_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(compat_lo) |-> $past(win_end));
  assert_type_on_window_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(sys_ntsc) |-> $past(win_end));
  assert_valid_on_window_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(sys_valid) |-> $past(win_end));
  assert_type_held_when_lost_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(sys_valid) |-> $stable(sys_ntsc));
endmodule

// File: tb/tb_vid_std_detect.sv
`timescale 1ns/1ps
module tb_vid_std_detect;
  localparam int WIN = 400;

  logic clk = 0, rst_n = 0, strap_in = 1, sys_clk_in = 0;
  logic ntsc_sel, compat_lo, sys_ntsc, sys_valid, mismatch;
  int total = 0, bad = 0, strap_mode = 0, sys_mode = 0;
  int edge_n = 0, r10_viol = 0, cyc = 0;
  logic [3:0] last_out;

  always #5 clk = ~clk;

  vid_std_detect #(.WIN_CYC(WIN), .TOGGLE_MIN(64), .PAL_LO(98), .PAL_HI(102),
                   .NTSC_LO(104), .NTSC_HI(108)) dut (
    .clk_ref(clk), .rst_n(rst_n), .strap_in(strap_in), .sys_clk_in(sys_clk_in),
    .ntsc_sel(ntsc_sel), .compat_lo(compat_lo), .sys_ntsc(sys_ntsc),
    .sys_valid(sys_valid), .mismatch(mismatch));

  // strap modes: 0 open-high, 1 low, 2 fast toggle (15 ns half), 3 slow toggle (100 ns half)
  initial forever begin
    case (strap_mode)
      0: begin strap_in = 1; #1; end
      1: begin strap_in = 0; #1; end
      2: begin #15 strap_in = ~strap_in; end
      default: begin #100 strap_in = ~strap_in; end
    endcase
  end

  // sys modes: 0 stopped, 1 PAL-scaled (20 ns half), 2 NTSC-scaled (19 ns half), 3 off-range (25 ns half)
  initial forever begin
    case (sys_mode)
      0: begin sys_clk_in = 0; #1; end
      1: begin #20 sys_clk_in = ~sys_clk_in; end
      2: begin #19 sys_clk_in = ~sys_clk_in; end
      default: begin #25 sys_clk_in = ~sys_clk_in; end
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n) edge_n++;
  end

  always @(negedge clk) begin
    if (rst_n && edge_n > 0) begin
      if ({ntsc_sel, compat_lo, sys_ntsc, sys_valid} !== last_out && (edge_n % WIN) != 0)
        r10_viol++;
    end
    last_out = {ntsc_sel, compat_lo, sys_ntsc, sys_valid};
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3 * WIN + 20) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    summary();
  end

  initial begin
    int exp_type;
    int exp_sel;
    int exp_cmp;
    int exp_val;
    int exp_mis;
    int sys_order [4] = '{1, 0, 2, 3};
    repeat (4) @(negedge clk);
    chk("R1 ntsc_sel", ntsc_sel, 0);
    chk("R1 compat_lo", compat_lo, 0);
    chk("R1 sys_valid", sys_valid, 0);
    chk("R1 sys_ntsc", sys_ntsc, 0);
    chk("R1 mismatch", mismatch, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {ntsc_sel, compat_lo, sys_ntsc, sys_valid}, 0);

    exp_type = 0;
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 4; k++) begin
        strap_mode = s;
        sys_mode = sys_order[k];
        settle();
        exp_sel = (s == 2);
        exp_cmp = (s == 1);
        exp_val = (sys_mode == 1 || sys_mode == 2);
        if (exp_val) exp_type = (sys_mode == 2);
        exp_mis = exp_val && (exp_type != exp_sel);
        chk(s == 2 ? "R2 ntsc_sel" : (s == 1 ? "R4 ntsc_sel" : "R3 ntsc_sel"), ntsc_sel, exp_sel);
        chk(s == 1 ? "R4 compat_lo" : "R3 compat_lo", compat_lo, exp_cmp);
        chk(sys_mode == 1 ? "R7 sys_valid" : (sys_mode == 2 ? "R8 sys_valid" : "R9 sys_valid"),
            sys_valid, exp_val);
        chk(sys_mode == 1 ? "R7 sys_ntsc" : (sys_mode == 2 ? "R8 sys_ntsc" : "R9 sys_ntsc held"),
            sys_ntsc, exp_type);
        chk("R11 mismatch", mismatch, exp_mis);
      end
    end

    // R5: short burst (about 80 edges total) from the open state
    strap_mode = 0; sys_mode = 1;
    settle();
    strap_mode = 2;
    #1200;
    strap_mode = 0;
    settle();
    chk("R5 burst ntsc_sel", ntsc_sel, 0);
    chk("R5 burst compat_lo", compat_lo, 0);

    // R6: slow toggling (about 40 edges per window) from the low state
    strap_mode = 1;
    settle();
    chk("R4 low before slow", compat_lo, 1);
    strap_mode = 3;
    settle();
    settle();
    chk("R6 slow compat_lo held", compat_lo, 1);
    chk("R6 slow ntsc_sel", ntsc_sel, 0);

    // R6: slow toggling after NTSC accepted keeps NTSC
    strap_mode = 2;
    settle();
    strap_mode = 3;
    settle();
    chk("R6 slow after toggle ntsc_sel held", ntsc_sel, 1);

    chk("R10 off-window changes", r10_viol, 0);
    summary();
  end
endmodule